// File: doc/BRIEF.md
# Multi-Standard Video Sync Generator

This block is the master timing source for an NTSC or PAL video encoder. A horizontal counter walks through the samples of each line, and a line counter walks through the lines of each frame. The counters advance only on cycles where the pixel clock enable is high. From their position the block produces active-low horizontal sync, vertical sync and composite blanking, a burst gate, and a one-sample start-of-active-video flag. All outputs are registered.

A 3-bit code selects one of five sampling modes. Each mode has its own line length and its own horizontal event positions. A select input chooses interlaced scanning (a full 525- or 625-line frame whose second field begins at mid-line) or progressive scanning (each field is a whole number of lines and repeats). The vertical extents are counted in half-lines. The mode code and the scan select are sampled only when a new frame begins, so a line or field never changes its geometry partway through.

Top module: `vid_sync_gen`

## Requirements
- R1: The samples per line are 858, 780, 910, 864 and 944 for mode codes 000 (13.5 MHz NTSC), 001 (square-pixel NTSC), 010 (4x subcarrier NTSC), 100 (13.5 MHz PAL) and 101 (square-pixel PAL). Codes 011, 110 and 111 behave as code 000.
- R2: `hsync_n` is low for horizontal positions 0 up to the sync width minus one. The sync width is 63, 58, 67, 63 and 69 in the mode order of R1.
- R3: `burst_gate` is high from the burst start (71, 65, 75, 75, 82) for the burst length (31, 31, 36, 31, 34). It stays low on vertically blanked half-lines.
- R4: `blank_n` is low when the horizontal position is below the blanking end (127, 116, 135, 142, 155) or at or above the front porch start (838, 762, 889, 844, 922).
- R5: An interlaced frame is L525 lines (NTSC) or L625 lines (PAL), 525 or 625 by default. A progressive field is (L-1)/2 lines, 262 or 312 by default, and every field repeats the same pattern.
- R6: The half-line index is 2*line, plus one when the horizontal position is at or past half the line length. `vsync_n` is low for the first 6 (NTSC) or 5 (PAL) half-lines of each field. In interlaced mode the second field starts at half-line index L525 or L625.
- R7: `blank_n` is low for the first vertical-blanking half-lines of each field: 40 (NTSC) or 50 (PAL) when interlaced, and 38 or 48 when progressive. These counts are parameters.
- R8: `active_start` is high for exactly one sample, at the blanking-end position, and only on half-lines that are not vertically blanked.
- R9: `mode_sel` and `interlace` are sampled only when the counters enter frame position 0. A change mid-frame has no effect until the next frame.
- R10: On a cycle with `pix_en` low, no output changes.
- R11: During reset, `hsync_n` and `vsync_n` are high and `blank_n`, `burst_gate` and `active_start` are low. The first enabled sample after reset is frame position 0, using the mode present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Sample enable; one sample per high cycle |
| mode_sel | input | 3 | Sampling mode code |
| interlace | input | 1 | 1 = interlaced, 0 = progressive |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Composite blanking, active low |
| burst_gate | output | 1 | Colour burst window |
| active_start | output | 1 | One-sample start of active video |

## Verification
Two events can coincide: a vertical boundary (the start of the second field, or the end of vertical blanking) can fall in the same sample as a horizontal event. This happens when the half-line index crosses the mid-line threshold while the burst window or front porch is being decoded. It also happens when a frame wrap reloads the mode in the same sample that the new position is decoded. The bench provokes both by sweeping every sample of complete interlaced frames and progressive field pairs in each mode. It uses a reduced line count so that mid-line field starts and blanking ends land on many horizontal positions. Each output is compared against an arithmetic model in every sample. In addition, the mode and scan inputs are changed mid-frame, and the next frame is expected to start with the new timing only at its frame boundary.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int HCNT_W = 10;

    typedef logic [HCNT_W-1:0] hcnt_t;

    typedef struct packed {
        hcnt_t total;
        hcnt_t hs_w;
        hcnt_t bu_start;
        hcnt_t bu_len;
        hcnt_t hb_end;
        hcnt_t fp_start;
        logic  pal;
    } htime_t;

    typedef enum logic [2:0] {
        VM_N601 = 3'b000,
        VM_NSQ  = 3'b001,
        VM_N4F  = 3'b010,
        VM_P601 = 3'b100,
        VM_PSQ  = 3'b101
    } vmode_e;

endpackage

// File: rtl/vsg_mode_table.sv
module vsg_mode_table
    import vsg_pkg::*;
(
    input  logic [2:0] code,
    output htime_t     tm
);

    always_comb begin
        case (code)
            VM_NSQ:  tm = '{total: 10'd780, hs_w: 10'd58, bu_start: 10'd65,
                             bu_len: 10'd31, hb_end: 10'd116, fp_start: 10'd762, pal: 1'b0};
            VM_N4F:  tm = '{total: 10'd910, hs_w: 10'd67, bu_start: 10'd75,
                             bu_len: 10'd36, hb_end: 10'd135, fp_start: 10'd889, pal: 1'b0};
            VM_P601: tm = '{total: 10'd864, hs_w: 10'd63, bu_start: 10'd75,
                             bu_len: 10'd31, hb_end: 10'd142, fp_start: 10'd844, pal: 1'b1};
            VM_PSQ:  tm = '{total: 10'd944, hs_w: 10'd69, bu_start: 10'd82,
                             bu_len: 10'd34, hb_end: 10'd155, fp_start: 10'd922, pal: 1'b1};
            default: tm = '{total: 10'd858, hs_w: 10'd63, bu_start: 10'd71,
                             bu_len: 10'd31, hb_end: 10'd127, fp_start: 10'd838, pal: 1'b0};
        endcase
    end

endmodule

// File: rtl/vsg_advance.sv
module vsg_advance
    import vsg_pkg::*;
#(
    parameter int LW   = 10,
    parameter int L525 = 525,
    parameter int L625 = 625
) (
    input  logic          run,
    input  hcnt_t         h,
    input  logic [LW-1:0] line,
    input  hcnt_t         cur_total,
    input  logic          cur_pal,
    input  logic          cur_il,
    input  htime_t        new_tm,
    input  logic          new_il,
    output hcnt_t         nh,
    output logic [LW-1:0] nline,
    output htime_t        ntm,
    output logic          nil,
    output logic          reload
);

    localparam logic [LW-1:0] LAST_I_525 = LW'(L525 - 1);
    localparam logic [LW-1:0] LAST_I_625 = LW'(L625 - 1);
    localparam logic [LW-1:0] LAST_P_525 = LW'((L525 - 1) / 2 - 1);
    localparam logic [LW-1:0] LAST_P_625 = LW'((L625 - 1) / 2 - 1);

    logic [LW-1:0] last_line;
    logic          line_end;

    always_comb begin
        if (cur_il) last_line = cur_pal ? LAST_I_625 : LAST_I_525;
        else        last_line = cur_pal ? LAST_P_625 : LAST_P_525;
        line_end = (h == cur_total - 10'd1);
        reload   = !run || (line_end && line == last_line);
        nh       = (!run || line_end) ? '0 : h + 10'd1;
        if (reload)        nline = '0;
        else if (line_end) nline = line + LW'(1);
        else               nline = line;
        ntm = new_tm;
        nil = new_il;
    end

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int LW      = 10,
    parameter int L525    = 525,
    parameter int L625    = 625,
    parameter int VS_525  = 6,
    parameter int VS_625  = 5,
    parameter int VBI_525 = 40,
    parameter int VBI_625 = 50,
    parameter int VBP_525 = 38,
    parameter int VBP_625 = 48
) (
    input  hcnt_t         h,
    input  logic [LW-1:0] line,
    input  htime_t        tm,
    input  logic          il,
    output logic          hs_n,
    output logic          vs_n,
    output logic          bl_n,
    output logic          bu,
    output logic          st
);

    localparam int HLW = LW + 1;

    logic           half;
    logic [HLW-1:0] hl;
    logic [HLW-1:0] f2;
    logic [HLW-1:0] rel;
    logic [HLW-1:0] vs_lim;
    logic [HLW-1:0] vb_lim;
    hcnt_t          bu_end;
    logic           vb;
    logic           hb;

    always_comb begin
        half   = (h >= {1'b0, tm.total[HCNT_W-1:1]});
        hl     = {line, half};
        f2     = tm.pal ? HLW'(L625) : HLW'(L525);
        rel    = (il && hl >= f2) ? hl - f2 : hl;
        vs_lim = tm.pal ? HLW'(VS_625) : HLW'(VS_525);
        if (il) vb_lim = tm.pal ? HLW'(VBI_625) : HLW'(VBI_525);
        else    vb_lim = tm.pal ? HLW'(VBP_625) : HLW'(VBP_525);
        vb     = (rel < vb_lim);
        hb     = (h < tm.hb_end) || (h >= tm.fp_start);
        bu_end = tm.bu_start + tm.bu_len;
        hs_n   = !(h < tm.hs_w);
        vs_n   = !(rel < vs_lim);
        bl_n   = !(hb || vb);
        bu     = (h >= tm.bu_start) && (h < bu_end) && !vb;
        st     = (h == tm.hb_end) && !vb;
    end

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
    import vsg_pkg::*;
#(
    parameter int L525    = 525,
    parameter int L625    = 625,
    parameter int VS_525  = 6,
    parameter int VS_625  = 5,
    parameter int VBI_525 = 40,
    parameter int VBI_625 = 50,
    parameter int VBP_525 = 38,
    parameter int VBP_625 = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_en,
    input  logic [2:0] mode_sel,
    input  logic       interlace,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       blank_n,
    output logic       burst_gate,
    output logic       active_start
);

    localparam int LW = $clog2((L625 > L525) ? L625 : L525);

    typedef struct packed {
        logic          run;
        logic          il;
        htime_t        tm;
        hcnt_t         h;
        logic [LW-1:0] line;
        logic          hs_n;
        logic          vs_n;
        logic          bl_n;
        logic          bu;
        logic          st;
    } state_t;

    state_t s_d, s_q;

    htime_t        tbl_tm;
    hcnt_t         nx_h;
    logic [LW-1:0] nx_line;
    htime_t        nx_tm;
    logic          nx_il;
    logic          nx_reload;
    logic          dc_hs_n, dc_vs_n, dc_bl_n, dc_bu, dc_st;
    htime_t        use_tm;
    logic          use_il;

    vsg_mode_table i_table (
        .code (mode_sel),
        .tm   (tbl_tm)
    );

    vsg_advance #(.LW(LW), .L525(L525), .L625(L625)) i_adv (
        .run       (s_q.run),
        .h         (s_q.h),
        .line      (s_q.line),
        .cur_total (s_q.tm.total),
        .cur_pal   (s_q.tm.pal),
        .cur_il    (s_q.il),
        .new_tm    (tbl_tm),
        .new_il    (interlace),
        .nh        (nx_h),
        .nline     (nx_line),
        .ntm       (nx_tm),
        .nil       (nx_il),
        .reload    (nx_reload)
    );

    always_comb begin
        use_tm = nx_reload ? nx_tm : s_q.tm;
        use_il = nx_reload ? nx_il : s_q.il;
    end

    vsg_decode #(
        .LW(LW), .L525(L525), .L625(L625),
        .VS_525(VS_525), .VS_625(VS_625),
        .VBI_525(VBI_525), .VBI_625(VBI_625),
        .VBP_525(VBP_525), .VBP_625(VBP_625)
    ) i_dec (
        .h    (nx_h),
        .line (nx_line),
        .tm   (use_tm),
        .il   (use_il),
        .hs_n (dc_hs_n),
        .vs_n (dc_vs_n),
        .bl_n (dc_bl_n),
        .bu   (dc_bu),
        .st   (dc_st)
    );

    always_comb begin
        s_d = s_q;
        if (pix_en) begin
            s_d.run  = 1'b1;
            s_d.h    = nx_h;
            s_d.line = nx_line;
            s_d.tm   = use_tm;
            s_d.il   = use_il;
            s_d.hs_n = dc_hs_n;
            s_d.vs_n = dc_vs_n;
            s_d.bl_n = dc_bl_n;
            s_d.bu   = dc_bu;
            s_d.st   = dc_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.hs_n <= 1'b1;
            s_q.vs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hsync_n      = s_q.hs_n;
    assign vsync_n      = s_q.vs_n;
    assign blank_n      = s_q.bl_n;
    assign burst_gate   = s_q.bu;
    assign active_start = s_q.st;

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_en,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       blank_n,
    input logic       burst_gate,
    input logic       active_start
);

    // R2: horizontal sync always sits inside horizontal blanking
    a_r2_hsync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !blank_n);

    // R6: vertical sync always sits inside vertical blanking
    a_r6_vsync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !blank_n);

    // R3: the burst window lies inside blanking
    a_r3_burst_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> !blank_n);

    // R8: the start flag marks a visible sample
    a_r8_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
        active_start |-> blank_n);

    // R8: the start flag lasts one sample
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        active_start && pix_en |=> !active_start);

    // R10: with no enable, nothing moves
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable({hsync_n, vsync_n, blank_n, burst_gate, active_start}));

endmodule

bind vid_sync_gen vsg_checker i_vsg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_en       (pix_en),
    .hsync_n      (hsync_n),
    .vsync_n      (vsync_n),
    .blank_n      (blank_n),
    .burst_gate   (burst_gate),
    .active_start (active_start)
);

// File: tb/test_vid_sync_gen.sv
`timescale 1ns/1ps
module test_vid_sync_gen;

    localparam int T525 = 15;
    localparam int T625 = 17;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_en;
    logic [2:0] mode_sel;
    logic       interlace;
    logic       hsync_n, vsync_n, blank_n, burst_gate, active_start;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    vid_sync_gen #(
        .L525(T525), .L625(T625),
        .VS_525(6), .VS_625(5),
        .VBI_525(8), .VBI_625(10),
        .VBP_525(7), .VBP_625(8)
    ) i_vid_sync_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_en       (pix_en),
        .mode_sel     (mode_sel),
        .interlace    (interlace),
        .hsync_n      (hsync_n),
        .vsync_n      (vsync_n),
        .blank_n      (blank_n),
        .burst_gate   (burst_gate),
        .active_start (active_start)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input logic en);
        @(negedge clk);
        pix_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic timing(input logic [2:0] c, output int tot, output int hsw,
                          output int bst, output int blen, output int hbe,
                          output int fps, output bit pal);
        case (c)
            3'b001:  begin tot = 780; hsw = 58; bst = 65; blen = 31; hbe = 116; fps = 762; pal = 0; end
            3'b010:  begin tot = 910; hsw = 67; bst = 75; blen = 36; hbe = 135; fps = 889; pal = 0; end
            3'b100:  begin tot = 864; hsw = 63; bst = 75; blen = 31; hbe = 142; fps = 844; pal = 1; end
            3'b101:  begin tot = 944; hsw = 69; bst = 82; blen = 34; hbe = 155; fps = 922; pal = 1; end
            default: begin tot = 858; hsw = 63; bst = 71; blen = 31; hbe = 127; fps = 838; pal = 0; end
        endcase
    endtask

    task automatic compare(input logic [2:0] c, input bit il, input int h,
                           input int ln, input string ctx);
        int tot, hsw, bst, blen, hbe, fps, hl, rel, lines, vsl, vbl;
        bit pal, vb, hb;
        timing(c, tot, hsw, bst, blen, hbe, fps, pal);
        lines = pal ? T625 : T525;
        hl    = 2 * ln + ((h >= tot / 2) ? 1 : 0);
        rel   = (il && hl >= lines) ? hl - lines : hl;
        vsl   = pal ? 5 : 6;
        vbl   = il ? (pal ? 10 : 8) : (pal ? 8 : 7);
        vb    = (rel < vbl);
        hb    = (h < hbe) || (h >= fps);
        chk($sformatf("R1 R2 hsync %s code=%b h=%0d line=%0d", ctx, c, h, ln), hsync_n, !(h < hsw));
        chk($sformatf("R5 R6 vsync %s code=%b il=%0d h=%0d line=%0d", ctx, c, il, h, ln), vsync_n, !(rel < vsl));
        chk($sformatf("R4 R7 blank %s code=%b il=%0d h=%0d line=%0d", ctx, c, il, h, ln), blank_n, !(hb || vb));
        chk($sformatf("R3 burst %s code=%b h=%0d line=%0d", ctx, c, h, ln), burst_gate,
            (h >= bst) && (h < bst + blen) && !vb);
        chk($sformatf("R8 start %s code=%b h=%0d line=%0d", ctx, c, h, ln), active_start,
            (h == hbe) && !vb);
    endtask

    task automatic run_frame(input logic [2:0] c, input bit il, input int nfields, input bit first);
        int tot, hsw, bst, blen, hbe, fps, nl;
        bit pal;
        logic [2:0] alt;
        logic [4:0] saved;
        string ctx;
        timing(c, tot, hsw, bst, blen, hbe, fps, pal);
        nl  = il ? (pal ? T625 : T525) : ((pal ? T625 : T525) - 1) / 2;
        alt = (tot == 944) ? 3'b001 : 3'b101;
        for (int f = 0; f < nfields; f++) begin
            mode_sel  = c;
            interlace = il;
            for (int ln = 0; ln < nl; ln++) begin
                for (int h = 0; h < tot; h++) begin
                    if (ln == 1 && h == 0) begin
                        mode_sel  = alt;
                        interlace = !il;
                    end
                    ctx = (first && f == 0 && ln == 0) ? "R11" : "R9";
                    step(1'b1);
                    compare(c, il, h, ln, ctx);
                    if (h == 0) begin
                        saved = {hsync_n, vsync_n, blank_n, burst_gate, active_start};
                        step(1'b0);
                        chk($sformatf("R10 hold line=%0d", ln),
                            ({hsync_n, vsync_n, blank_n, burst_gate, active_start} == saved), 1'b1);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [5];
        codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
        codes[3] = 3'b100; codes[4] = 3'b101;
        rst_n     = 1'b0;
        pix_en    = 1'b0;
        mode_sel  = 3'b000;
        interlace = 1'b1;
        repeat (3) step(1'b0);
        chk("R11 reset hsync", hsync_n, 1'b1);
        chk("R11 reset vsync", vsync_n, 1'b1);
        chk("R11 reset blank", blank_n, 1'b0);
        chk("R11 reset burst", burst_gate, 1'b0);
        chk("R11 reset start", active_start, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) step(1'b0);
        chk("R10 R11 idle after reset hsync", hsync_n, 1'b1);
        chk("R10 R11 idle after reset vsync", vsync_n, 1'b1);
        chk("R10 R11 idle after reset blank", blank_n, 1'b0);
        for (int i = 0; i < 5; i++) begin
            run_frame(codes[i], 1'b1, 1, i == 0);
            run_frame(codes[i], 1'b0, 2, 1'b0);
        end
        run_frame(3'b110, 1'b0, 1, 1'b0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule